// File: doc/BRIEF.md
# Interleave Decoder Target Lookup

This block turns a host physical address into the number of the downstream port that serves it. It holds the setup of one memory decoder: a control word with a committed flag, an interleave-ways code and a granularity code, plus eight 8-bit port numbers packed into two 32-bit list words. Software loads these through a simple write port. A lookup request then selects one of the list entries from the address bits just above the interleave granule.

The granule is 256 bytes shifted left by the granularity code. The ways code gives a power-of-two number of targets, so the entry index is the next few address bits above the granule. The result is registered. It comes back one cycle after the request with a valid strobe, a hit flag and the port number. A decoder that is not committed, or one whose ways code asks for more than eight targets, reports no hit.

Top module: `ilv_port_lookup`

## Requirements
- R1: After reset `rsp_valid` and `rsp_hit` are 0 and the decoder is uncommitted, so a lookup made before any control write misses.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_req` at 1, and is 0 otherwise.
- R3: A lookup reports no hit (`rsp_hit` 0) while the committed bit (control bit 0) is clear.
- R4: The entry index is (address / (256 << G)) mod 2^W, that is, address bits [8+G+W-1 : 8+G]. G is the granularity code in control bits 11:8 and W is the ways code in control bits 7:4. With W = 0 the index is always 0.
- R5: Indexes 0 to 3 take the port number from list word low (`cfg_sel` 1), 8 bits per index, with index 0 in bits 7:0.
- R6: Indexes 4 to 7 take the port number from list word high (`cfg_sel` 2), at bit offset (index - 4) * 8.
- R7: A ways code above 3 gives no hit, even when the decoder is committed.
- R8: While the decoder is committed, a control write (`cfg_sel` 0) with bit 0 set is ignored. A control write with bit 0 clear is applied in full, so it also uncommits the decoder.
- R9: On a valid response without a hit, `rsp_port` is 0.
- R10: Ways and granularity are taken from the current control word on every lookup, so reprogramming the decoder changes the mapping for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 list low, 2 list high, 3 none |
| cfg_wdata | input | 32 | Register write data |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Host physical address to decode |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Lookup found a target |
| rsp_port | output | 8 | Downstream port number (0 on a miss) |

## Verification
The hardest case to reach is a control write that arrives while the decoder is committed. Its effect can only be seen through later lookups, because no register can be read back. The stimulus commits a decoder with eight ways, then writes a one-way control word that keeps the committed bit set. It then looks up an address whose index is 5. Port 5 must still come back; had the write been applied, the index would be 0. A second write clears the committed bit, and the next lookup must miss.

// File: rtl/ilv_port_lookup.sv
module ilv_port_lookup #(
  parameter int ADDR_W    = 52,
  parameter int GRAN_BASE = 8,
  parameter int CODE_W    = 4,
  parameter int PORT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PORT_W-1:0] rsp_port
);
  localparam int NTGT  = 64 / PORT_W;
  localparam int IDX_W = $clog2(NTGT);

  logic              commit_q;
  logic [CODE_W-1:0] ways_q, gran_q;
  logic [63:0]       list_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      ways_q   <= '0;
      gran_q   <= '0;
      list_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (!commit_q || !cfg_wdata[0]) begin
          commit_q <= cfg_wdata[0];
          ways_q   <= cfg_wdata[4 +: CODE_W];
          gran_q   <= cfg_wdata[8 +: CODE_W];
        end
        2'd1: list_q[31:0]  <= cfg_wdata;
        2'd2: list_q[63:32] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic [ADDR_W-1:0] shifted;
  logic [IDX_W:0]    mask;
  logic [IDX_W-1:0]  idx;
  logic              ways_ok, hit_d;

  assign shifted = lk_addr >> (GRAN_BASE + int'(gran_q));
  assign ways_ok = (int'(ways_q) <= IDX_W);
  assign mask    = ({{IDX_W{1'b0}}, 1'b1} << ways_q[1:0]) - 1'b1;
  assign idx     = shifted[IDX_W-1:0] & mask[IDX_W-1:0];
  assign hit_d   = commit_q && ways_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_port  <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && hit_d;
      rsp_port  <= (lk_req && hit_d) ? list_q[idx*PORT_W +: PORT_W] : '0;
    end
  end

  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  p_uncommitted_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !commit_q) |=> !rsp_hit);
  p_bad_ways_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && ways_q > 3) |=> !rsp_hit);
  p_locked_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_q && cfg_we && cfg_sel == 2'd0 && cfg_wdata[0])
      |=> (commit_q && $stable(ways_q) && $stable(gran_q)));
  p_miss_port_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_port == '0);
  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

// File: tb/ilv_port_lookup_tb.sv
module ilv_port_lookup_tb;
  localparam int ADDR_W = 52;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd3;
  logic [31:0]       cfg_wdata = '0;
  logic              lk_req = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              rsp_valid, rsp_hit;
  logic [7:0]        rsp_port;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] m_list = '0;

  always #10 clk = ~clk;

  ilv_port_lookup #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lk_req(lk_req), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit c, input int w, input int g);
    return {20'b0, 4'(g), 4'(w), 3'b0, c};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    if (sel == 2'd1) m_list[31:0] = d;
    if (sel == 2'd2) m_list[63:32] = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic look(input string req, input logic [ADDR_W-1:0] a,
                      input bit exp_hit, input logic [7:0] exp_port);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    check({req, " port"}, 32'(rsp_port), 32'(exp_port));
  endtask

  function automatic logic [7:0] model(input logic [ADDR_W-1:0] a, input int w, input int g);
    int idx = int'((a >> (8 + g)) & ((64'd1 << w) - 1));
    return m_list[idx*8 +: 8];
  endfunction

  task automatic t_reset;
    check("R1 valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 hit after reset", 32'(rsp_hit), 32'd0);
    look("R1 R3 uncommitted", 52'h1234500, 1'b0, 8'h00);
    @(negedge clk);
    check("R2 idle no valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_eight_ways;
    wr(2'd1, 32'h13121110);
    wr(2'd2, 32'h17161514);
    wr(2'd0, ctl(1'b1, 3, 0));
    for (int p = 0; p < 8; p++) begin
      logic [ADDR_W-1:0] a = (52'(p) << 8) | 52'hA5000_5A;
      look(p < 4 ? "R4 R5 low word" : "R4 R6 high word", a, 1'b1, 8'h10 + 8'(p));
    end
  endtask

  task automatic t_gran;
    wr(2'd0, ctl(1'b0, 0, 0));
    wr(2'd1, 32'hD4C3B2A1);
    wr(2'd0, ctl(1'b1, 2, 3));
    for (int k = 0; k < 6; k++) begin
      logic [ADDR_W-1:0] a = 52'h3C0_0000 + 52'(k) * 52'h1F37;
      look("R4 R10 gran3 ways2", a, 1'b1, model(a, 2, 3));
    end
    look("R4 index 2 at bit 11", 52'h1000, 1'b1, 8'hC3);
  endtask

  task automatic t_one_way;
    wr(2'd0, ctl(1'b0, 0, 0));
    wr(2'd0, ctl(1'b1, 0, 5));
    look("R4 R10 one way", 52'hFFFF_FFFF, 1'b1, 8'hA1);
  endtask

  task automatic t_bad_ways;
    wr(2'd0, ctl(1'b0, 0, 0));
    wr(2'd0, ctl(1'b1, 5, 0));
    look("R7 R9 ways code 5", 52'h700, 1'b0, 8'h00);
  endtask

  task automatic t_locked;
    wr(2'd0, ctl(1'b0, 0, 0));
    wr(2'd1, 32'h13121110);
    wr(2'd2, 32'h17161514);
    wr(2'd0, ctl(1'b1, 3, 0));
    wr(2'd0, ctl(1'b1, 0, 0));
    look("R8 write while committed ignored", 52'h500, 1'b1, 8'h15);
    wr(2'd0, ctl(1'b0, 3, 0));
    look("R8 R3 decommit write applied", 52'h500, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_eight_ways();
    t_gran();
    t_one_way();
    t_bad_ways();
    t_locked();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule